// File: doc/BRIEF.md
# Pseudo-Random One-of-Sixteen Selector

This block steps a 16-stage shift register through a pseudo-random sequence and turns four of its stages into a one-hot choice among sixteen outputs. On every cycle in which the step enable is high, exactly one of the sixteen select lines moves to a new, pseudo-randomly chosen position. A typical use is a test stimulus that needs a reproducible but scattered pick of one channel out of sixteen at a slow step rate. That rate, on the order of 12.5 kHz, comes from an enable pulse that the surrounding logic derives from the system clock.

The stages are numbered 0 to 15. Each step moves every stage one place toward stage 15. Stage 0 takes in the exclusive-OR of stages 14 and 13. With these taps, stages 0 to 14 form a maximal-length 15-bit sequence with a period of 32767 steps, and stage 15 is only a delayed copy of stage 14.

The index is stages 3..0, with stage 3 as the most significant bit. Over one full period the index value 0 appears one time fewer than each of the other values. A seed load port lets the sequence start at a chosen state. Any seed that would leave stages 14..0 all zero is replaced by a fixed nonzero default, so the register can never lock up.

Top module: `onehot_prng_sel`

## Requirements
- R1: While reset is high, and in the first cycle after it, the register holds 16'hACE1 and the select output is 16'h0002.
- R2: On a clock edge with step_en high and seed_load low, the register takes the value {state[14:0], state[14] ^ state[13]}.
- R3: On a clock edge with both step_en and seed_load low, the register and the select output keep their values.
- R4: After every clock edge, the select output equals 1 shifted left by state[3:0], with state[3] as the most significant index bit.
- R5: Exactly one select line is high in every cycle after reset.
- R6: On a clock edge with seed_load high and seed[14:0] nonzero, the register takes seed exactly, including bit 15.
- R7: On a clock edge with seed_load high and seed[14:0] zero, the register takes the default 16'hACE1 instead of the seed.
- R8: When seed_load and step_en are high on the same edge, the load takes effect and no shift is applied.
- R9: With step_en held high, state[14:0] first returns to its starting value after exactly 32767 steps.
- R10: Over 32767 consecutive steps, index 0 is selected 2047 times and every other index is selected 2048 times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Enable pulse: advance the sequence by one step |
| seed_load | input | 1 | Load the seed value on this edge |
| seed | input | 16 | Seed value for a load |
| state | output | 16 | Current register contents, stage 0 in bit 0 |
| sel | output | 16 | Registered one-hot select, bit k high when the index is k |

## Verification
Two functions can meet on the same edge: a seed load and a step. The scoreboard drives both high together, once with a normal seed and once with a seed whose low fifteen bits are zero. It expects the loaded value, or the default for the zero seed, with no shift applied. It also expects the one-hot output to show the index of that loaded value. It then steps straight on from the loaded value, so a shift that slipped in on top of the load would show up as a mismatch on every later item.

// File: rtl/sel_pkg.sv
package sel_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned OUT_N    = 1 << IDX_W;
  localparam logic [REG_W-1:0] SEED_DEFAULT = 16'hACE1;

  typedef logic [REG_W-1:0] reg_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [OUT_N-1:0] hot_t;
endpackage

// File: rtl/seed_guard.sv
module seed_guard #(
  parameter int unsigned W        = 16,
  parameter int unsigned LIVE_TOP = 14,
  parameter logic [W-1:0] FALLBACK = 16'hACE1
) (
  input  logic [W-1:0] seed_in,
  output logic [W-1:0] seed_ok
);
  localparam int unsigned LIVE_W = LIVE_TOP + 1;

  logic dead;

  always_comb begin
    dead    = (seed_in[LIVE_W-1:0] == '0);
    seed_ok = dead ? FALLBACK : seed_in;
  end
endmodule

// File: rtl/prng_shift.sv
module prng_shift #(
  parameter int unsigned W      = 16,
  parameter int unsigned TAP_A  = 14,
  parameter int unsigned TAP_B  = 13,
  parameter logic [W-1:0] INIT  = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt,
  output logic         upd
);
  localparam int unsigned LIVE_W = TAP_A + 1;

  logic fb;

  always_comb begin
    fb    = q[TAP_A] ^ q[TAP_B];
    upd   = load | step;
    if (load)      q_nxt = load_val;
    else if (step) q_nxt = {q[W-2:0], fb};
    else           q_nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= INIT;
    else if (upd) q <= q_nxt;
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> (q == $past(q)));  // R3
  AST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (q[W-1:1] == $past(q[W-2:0])));  // R2
  AST_LIVE: assert property (@(posedge clk) disable iff (rst)
    q[LIVE_W-1:0] != '0);  // R7
endmodule

// File: rtl/idx_onehot_dec.sv
module idx_onehot_dec #(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned OUT_N   = 16,
  parameter logic [IDX_W-1:0] RST_IDX = 4'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [IDX_W-1:0] idx,
  output logic [OUT_N-1:0] hot
);
  logic [OUT_N-1:0] hot_nxt;

  for (genvar k = 0; k < OUT_N; k++) begin : g_line
    assign hot_nxt[k] = (idx == IDX_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst)      hot <= OUT_N'(1) << RST_IDX;
    else if (upd) hot <= hot_nxt;
  end

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    $countones(hot) == 1);  // R5
endmodule

// File: rtl/onehot_prng_sel.sv
module onehot_prng_sel
  import sel_pkg::*;
#(
  parameter int unsigned TAP_A   = 14,
  parameter int unsigned TAP_B   = 13,
  parameter int unsigned IDX_LSB = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             seed_load,
  input  logic [REG_W-1:0] seed,
  output logic [REG_W-1:0] state,
  output logic [OUT_N-1:0] sel
);
  localparam int unsigned LIVE_W  = TAP_A + 1;
  localparam idx_t        RST_IDX = SEED_DEFAULT[IDX_LSB +: IDX_W];

  reg_t seed_ok;
  reg_t st_nxt;
  logic upd;

  seed_guard #(
    .W(REG_W), .LIVE_TOP(TAP_A), .FALLBACK(SEED_DEFAULT)
  ) u_guard (
    .seed_in(seed),
    .seed_ok(seed_ok)
  );

  prng_shift #(
    .W(REG_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .INIT(SEED_DEFAULT)
  ) u_shift (
    .clk(clk),
    .rst(rst),
    .step(step_en),
    .load(seed_load),
    .load_val(seed_ok),
    .q(state),
    .q_nxt(st_nxt),
    .upd(upd)
  );

  idx_onehot_dec #(
    .IDX_W(IDX_W), .OUT_N(OUT_N), .RST_IDX(RST_IDX)
  ) u_dec (
    .clk(clk),
    .rst(rst),
    .upd(upd),
    .idx(st_nxt[IDX_LSB +: IDX_W]),
    .hot(sel)
  );

  AST_SEL_MATCH: assert property (@(posedge clk) disable iff (rst)
    sel == (OUT_N'(1) << state[IDX_LSB +: IDX_W]));  // R4
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed[LIVE_W-1:0] != '0) |=> (state == $past(seed)));  // R6
  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed[LIVE_W-1:0] == '0) |=> (state == SEED_DEFAULT));  // R7
  AST_LOAD_OVER_STEP: assert property (@(posedge clk) disable iff (rst)
    (seed_load && step_en && seed[LIVE_W-1:0] != '0) |=> (state == $past(seed)));  // R8
endmodule

// File: tb/sim_onehot_prng_sel.sv
module sim_onehot_prng_sel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic        seed_load = 1'b0;
  logic [15:0] seed = '0;
  logic [15:0] state;
  logic [15:0] sel;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [15:0] exp_st_q[$];
  logic [15:0] exp_sel_q[$];
  string       tag_q[$];
  logic [15:0] model;

  always #10 clk = ~clk;

  onehot_prng_sel u0 (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_load(seed_load),
    .seed(seed), .state(state), .sel(sel)
  );

  function automatic logic [15:0] ref_next(logic [15:0] s, logic st, logic ld, logic [15:0] sd);
    if (ld) return (sd[14:0] == 15'd0) ? 16'hACE1 : sd;
    if (st) return {s[14:0], s[14] ^ s[13]};
    return s;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: drive at negedge, push what the next posedge must produce
  task automatic drive(logic st, logic ld, logic [15:0] sd, string req);
    @(negedge clk);
    step_en = st; seed_load = ld; seed = sd;
    model = ref_next(model, st, ld, sd);
    exp_st_q.push_back(model);
    exp_sel_q.push_back(16'(1) << model[3:0]);
    tag_q.push_back(req);
  endtask

  // monitor: compare after each posedge
  always begin
    @(posedge clk);
    #2;
    if (exp_st_q.size() > 0) begin
      logic [15:0] es;
      logic [15:0] eo;
      string t;
      es = exp_st_q.pop_front();
      eo = exp_sel_q.pop_front();
      t = tag_q.pop_front();
      check(t, state, es);
      check({t, "/R4"}, sel, eo);
      n_run++;
      if ($countones(sel) != 1) begin
        n_fail++;
        $display("FAIL R5: actual %h expected one hot", sel);
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt[16];
    int first_ret;
    logic [14:0] start;
    model = 16'hACE1;
    repeat (3) @(negedge clk);
    check("R1", state, 16'hACE1);
    check("R1", sel, 16'h0002);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    check("R1", state, 16'hACE1);
    check("R1", sel, 16'h0002);

    for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 16'h0000, "R2");
    for (int i = 0; i < 4; i++)  drive(1'b0, 1'b0, 16'hFFFF, "R3");
    drive(1'b0, 1'b1, 16'h1234, "R6");
    drive(1'b1, 1'b0, 16'h0000, "R2");
    drive(1'b0, 1'b1, 16'hF00F, "R6");
    drive(1'b0, 1'b1, 16'h8000, "R7");
    drive(1'b0, 1'b1, 16'h0000, "R7");
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 16'h0000, "R2");
    drive(1'b1, 1'b1, 16'h5A5A, "R8");
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 16'h0000, "R8");
    drive(1'b1, 1'b1, 16'h8000, "R8");
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 16'h0000, "R8");
    drive(1'b0, 1'b1, 16'h7FFF, "R6");
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 16'h0000, "R3");
    @(negedge clk);
    step_en = 1'b0; seed_load = 1'b0;
    repeat (3) @(negedge clk);

    // long run: period and index distribution
    for (int k = 0; k < 16; k++) cnt[k] = 0;
    start = state[14:0];
    first_ret = 0;
    step_en = 1'b1;
    for (int i = 1; i <= 32767; i++) begin
      @(posedge clk); #2;
      for (int k = 0; k < 16; k++) if (sel[k]) cnt[k]++;
      if (first_ret == 0 && state[14:0] == start) first_ret = i;
    end
    @(negedge clk);
    step_en = 1'b0;
    check("R9", 16'(first_ret), 16'(32767));
    check("R10", 16'(cnt[0]), 16'd2047);
    for (int k = 1; k < 16; k++) check("R10", 16'(cnt[k]), 16'd2048);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule